// File: doc/BRIEF.md
# Task Address Relocation and Reserved-Opcode Trap Unit

This unit sits between a 16-bit processor and a memory that several tasks share. Every data or instruction access the processor issues carries a logical address. The unit adds the running task's base offset to that address and passes the sum to memory as the physical address. In the same cycle it compares the logical address against the task's limit. An access that lies beyond the limit, or whose relocated address would not fit in 16 bits, is refused. The memory strobe stays low, the offending logical address is captured, and a fault interrupt follows. Tasks that share the memory therefore cannot reach each other's storage by accident.

The unit also inspects each instruction word the processor fetches. Opcodes inside a programmable window belong to a band that the processor itself never executes, and the unit claims them. Opcodes that also fall inside a second programmable window are handed to a direct dataway-operation path. Every other trapped opcode raises a call into the executive kernel. The trapped word is presented along with either dispatch strobe.

Only the supervisor can change the base, the limit and the four window bounds. The kernel loads them before it switches to a task.

Top module: `reloc_trap_unit`

## Requirements
- R1: When `reqValid` is high and the access does not fault, `memStrobe` is high in the same cycle and `memAddr` equals base + `reqAddr`.
- R2: An access whose logical address `reqAddr` is greater than the limit register is a fault, and `memStrobe` is low in that cycle.
- R3: An access for which base + `reqAddr` exceeds 16'hFFFF is a fault, and `memStrobe` is low in that cycle.
- R4: After a faulting access, `faultIrq` is high for exactly the next cycle. From that cycle on, `faultAddr` holds the faulting logical address until the next fault.
- R5: A word presented with `opValid` that lies inside the trap window (lower bound ≤ word ≤ upper bound, inclusive) raises exactly one dispatch strobe in the next cycle, with `trapCode` equal to the word. A word outside the window raises neither strobe.
- R6: A trapped word that also lies inside the direct window (inclusive) raises `directStrobe`. Any other trapped word raises `kernelStrobe`. A word inside the direct window but outside the trap window raises neither strobe.
- R7: A configuration write takes effect from the next cycle, and only when `cfgWrite` and `supervisor` are both high. The `cfgSel` codes are: 0 base, 1 limit, 2 trap lower bound, 3 trap upper bound, 4 direct lower bound, 5 direct upper bound. Codes 6 and 7 change nothing.
- R8: After reset, base is 0 and limit is 16'hFFFF. Both windows are empty: each lower bound is 16'hFFFF and each upper bound is 0. All strobes and `faultIrq` are low, and `faultAddr` and `trapCode` are 0.
- R9: Access checking and opcode trapping act independently. A fault and a trap presented in the same cycle both produce their results in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supervisor | input | 1 | Processor is in supervisor mode; enables configuration writes |
| cfgWrite | input | 1 | Configuration write request |
| cfgSel | input | 3 | Configuration register select |
| cfgData | input | 16 | Configuration write data |
| reqValid | input | 1 | Processor access request |
| reqAddr | input | 16 | Logical address of the access |
| memStrobe | output | 1 | Memory access strobe, suppressed on fault |
| memAddr | output | 16 | Relocated physical address |
| faultIrq | output | 1 | One-cycle fault interrupt |
| faultAddr | output | 16 | Last faulting logical address |
| opValid | input | 1 | Fetched instruction word is valid |
| opWord | input | 16 | Fetched instruction word |
| directStrobe | output | 1 | Trapped opcode goes to the direct dataway path |
| kernelStrobe | output | 1 | Trapped opcode goes to the kernel |
| trapCode | output | 16 | Opcode of the last trap |

## Verification
A faulting access and a trapped fetch can arrive in the same cycle, and a configuration write can also coincide with an access. The bench sweeps logical addresses and fetched words together so that limit faults, carry faults and direct and kernel traps overlap in many combinations. It then expects both the interrupt and the correct dispatch strobe in the following cycle. A base write issued in the same cycle as an access must leave that access relocated by the old base, which shows the write lands only on the next edge.

// File: rtl/reloc_trap_pkg.sv
package reloc_trap_pkg;
  localparam int unsigned NUM_CFG = 6;
  localparam int unsigned SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_BASE    = 3'd0,
    SEL_LIMIT   = 3'd1,
    SEL_TRAP_LO = 3'd2,
    SEL_TRAP_HI = 3'd3,
    SEL_DIR_LO  = 3'd4,
    SEL_DIR_HI  = 3'd5
  } cfgSel_e;

  typedef struct packed {
    logic [NUM_CFG-1:0] ldCfg;
    logic               capFault;
    logic               capOp;
  } dpStrobe_t;
endpackage

// File: rtl/reloc_trap_datapath.sv
module reloc_trap_datapath
  import reloc_trap_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobe_t    strobe,
  input  logic [W-1:0] cfgData,
  input  logic [W-1:0] reqAddr,
  input  logic [W-1:0] opWord,
  output logic [W-1:0] memAddr,
  output logic         violation,
  output logic         inTrap,
  output logic         inDirect,
  output logic [W-1:0] faultAddr,
  output logic [W-1:0] trapCode
);
  logic [W-1:0] cfgReg [NUM_CFG];
  logic [W:0]   sum;

  // Windows reset empty (lower bound above upper); the limit resets to the top.
  function automatic logic [W-1:0] cfgResetVal(input int idx);
    if (idx == int'(SEL_LIMIT) || idx == int'(SEL_TRAP_LO) || idx == int'(SEL_DIR_LO))
      return '1;
    return '0;
  endfunction

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN)                  cfgReg[i] <= cfgResetVal(i);
      else if (strobe.ldCfg[i])   cfgReg[i] <= cfgData;
    end
  end

  // Limit compare uses the logical address, so it runs in parallel with the adder.
  always_comb begin
    sum       = {1'b0, cfgReg[SEL_BASE]} + {1'b0, reqAddr};
    memAddr   = sum[W-1:0];
    violation = sum[W] || (reqAddr > cfgReg[SEL_LIMIT]);
    inTrap    = (opWord >= cfgReg[SEL_TRAP_LO]) && (opWord <= cfgReg[SEL_TRAP_HI]);
    inDirect  = (opWord >= cfgReg[SEL_DIR_LO])  && (opWord <= cfgReg[SEL_DIR_HI]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultAddr <= '0;
      trapCode  <= '0;
    end else begin
      if (strobe.capFault) faultAddr <= reqAddr;
      if (strobe.capOp)    trapCode  <= opWord;
    end
  end
endmodule

// File: rtl/reloc_trap_ctrl.sv
module reloc_trap_ctrl
  import reloc_trap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             supervisor,
  input  logic             cfgWrite,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             reqValid,
  input  logic             violation,
  input  logic             opValid,
  input  logic             inTrap,
  input  logic             inDirect,
  output dpStrobe_t        strobe,
  output logic             memStrobe,
  output logic             faultIrq,
  output logic             directStrobe,
  output logic             kernelStrobe
);
  for (genvar i = 0; i < NUM_CFG; i++) begin : g_ld
    assign strobe.ldCfg[i] = cfgWrite && supervisor && (cfgSel == SEL_W'(i));
  end

  assign strobe.capFault = reqValid && violation;
  assign strobe.capOp    = opValid && inTrap;
  assign memStrobe       = reqValid && !violation;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultIrq     <= 1'b0;
      directStrobe <= 1'b0;
      kernelStrobe <= 1'b0;
    end else begin
      faultIrq     <= strobe.capFault;
      directStrobe <= strobe.capOp && inDirect;
      kernelStrobe <= strobe.capOp && !inDirect;
    end
  end
endmodule

// File: rtl/reloc_trap_unit.sv
module reloc_trap_unit
  import reloc_trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supervisor,
  input  logic        cfgWrite,
  input  logic [2:0]  cfgSel,
  input  logic [15:0] cfgData,
  input  logic        reqValid,
  input  logic [15:0] reqAddr,
  output logic        memStrobe,
  output logic [15:0] memAddr,
  output logic        faultIrq,
  output logic [15:0] faultAddr,
  input  logic        opValid,
  input  logic [15:0] opWord,
  output logic        directStrobe,
  output logic        kernelStrobe,
  output logic [15:0] trapCode
);
  dpStrobe_t strobe;
  logic      violation, inTrap, inDirect;

  reloc_trap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .supervisor(supervisor), .cfgWrite(cfgWrite),
    .cfgSel(cfgSel), .reqValid(reqValid), .violation(violation),
    .opValid(opValid), .inTrap(inTrap), .inDirect(inDirect),
    .strobe(strobe), .memStrobe(memStrobe), .faultIrq(faultIrq),
    .directStrobe(directStrobe), .kernelStrobe(kernelStrobe)
  );

  reloc_trap_datapath #(.W(16)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgData(cfgData),
    .reqAddr(reqAddr), .opWord(opWord), .memAddr(memAddr),
    .violation(violation), .inTrap(inTrap), .inDirect(inDirect),
    .faultAddr(faultAddr), .trapCode(trapCode)
  );
endmodule

// File: rtl/reloc_trap_checker.sv
module reloc_trap_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [15:0] reqAddr,
  input logic        memStrobe,
  input logic [15:0] memAddr,
  input logic        faultIrq,
  input logic [15:0] faultAddr,
  input logic        opValid,
  input logic [15:0] opWord,
  input logic        directStrobe,
  input logic        kernelStrobe,
  input logic [15:0] trapCode
);
  // R1: a granted access never wraps below its logical address
  a_r1_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    memStrobe |-> (memAddr >= reqAddr));

  // R2: the strobe is only ever raised for a real request
  a_r2_strobe_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    memStrobe |-> reqValid);

  // R4: a refused request is followed by the interrupt
  a_r4_irq_after_block: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !memStrobe) |=> faultIrq);

  // R4: the captured address is the logical address of the refused request
  a_r4_addr_capture: assert property (@(posedge clk) disable iff (!rstN)
    faultIrq |-> (faultAddr == $past(reqAddr)));

  // R4: the captured address holds between faults
  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    !faultIrq |-> $stable(faultAddr));

  // R6: at most one dispatch path per trap
  a_r6_one_dispatch: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({directStrobe, kernelStrobe}));

  // R5: a dispatch carries the word fetched one cycle earlier
  a_r5_code_matches: assert property (@(posedge clk) disable iff (!rstN)
    (directStrobe || kernelStrobe) |-> ($past(opValid) && trapCode == $past(opWord)));
endmodule

bind reloc_trap_unit reloc_trap_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .memStrobe(memStrobe), .memAddr(memAddr), .faultIrq(faultIrq),
  .faultAddr(faultAddr), .opValid(opValid), .opWord(opWord),
  .directStrobe(directStrobe), .kernelStrobe(kernelStrobe), .trapCode(trapCode)
);

// File: tb/reloc_trap_unit_bench.sv
module reloc_trap_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        supervisor = 1'b0, cfgWrite = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [15:0] cfgData = '0;
  logic        reqValid = 1'b0, opValid = 1'b0;
  logic [15:0] reqAddr = '0, opWord = '0;
  logic        memStrobe, faultIrq, directStrobe, kernelStrobe;
  logic [15:0] memAddr, faultAddr, trapCode;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] mBase = 16'h0000, mLimit = 16'hFFFF;
  logic [15:0] mTrLo = 16'hFFFF, mTrHi = 16'h0000, mDirLo = 16'hFFFF, mDirHi = 16'h0000;
  logic [15:0] lastFault = 16'h0000;

  always #10 clk = ~clk;

  reloc_trap_unit u_reloc_trap_unit (
    .clk(clk), .rstN(rstN), .supervisor(supervisor), .cfgWrite(cfgWrite),
    .cfgSel(cfgSel), .cfgData(cfgData), .reqValid(reqValid), .reqAddr(reqAddr),
    .memStrobe(memStrobe), .memAddr(memAddr), .faultIrq(faultIrq),
    .faultAddr(faultAddr), .opValid(opValid), .opWord(opWord),
    .directStrobe(directStrobe), .kernelStrobe(kernelStrobe), .trapCode(trapCode)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      errors++; checks++;
      $display("FAIL R1 watchdog expired actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; combinational results checked in the same cycle,
  // registered results checked one cycle later.
  task automatic step(input string tag, input bit cw, input logic [2:0] sel,
                      input logic [15:0] cd, input bit sup, input bit rv,
                      input logic [15:0] ra, input bit ov, input logic [15:0] ow);
    bit eCarry, eOver, eFault, eTrap, eDir;
    logic [15:0] eAddr;
    string lbl;
    cfgWrite = cw; cfgSel = sel; cfgData = cd; supervisor = sup;
    reqValid = rv; reqAddr = ra; opValid = ov; opWord = ow;
    #1;
    eCarry = (32'(mBase) + 32'(ra)) > 32'h0000FFFF;
    eOver  = ra > mLimit;
    eFault = rv && (eCarry || eOver);
    eAddr  = mBase + ra;
    lbl    = eCarry ? "R3" : (eOver ? "R2" : "R1");
    check(memStrobe == (rv && !eFault), {tag, "/", lbl}, "memStrobe",
          32'(memStrobe), 32'(rv && !eFault));
    if (rv && !eFault)
      check(memAddr == eAddr, {tag, "/R1"}, "memAddr", 32'(memAddr), 32'(eAddr));
    eTrap = ov && (ow >= mTrLo) && (ow <= mTrHi);
    eDir  = eTrap && (ow >= mDirLo) && (ow <= mDirHi);
    if (eFault) lastFault = ra;
    if (cw && sup) begin
      case (sel)
        3'd0: mBase  = cd;
        3'd1: mLimit = cd;
        3'd2: mTrLo  = cd;
        3'd3: mTrHi  = cd;
        3'd4: mDirLo = cd;
        3'd5: mDirHi = cd;
        default: ;
      endcase
    end
    @(negedge clk);
    cfgWrite = 1'b0; supervisor = 1'b0; reqValid = 1'b0; opValid = 1'b0;
    check(faultIrq == eFault, {tag, "/R4"}, "faultIrq", 32'(faultIrq), 32'(eFault));
    check(faultAddr == lastFault, {tag, "/R4"}, "faultAddr", 32'(faultAddr), 32'(lastFault));
    check(directStrobe == eDir, {tag, "/R6"}, "directStrobe", 32'(directStrobe), 32'(eDir));
    check(kernelStrobe == (eTrap && !eDir), {tag, "/R5"}, "kernelStrobe",
          32'(kernelStrobe), 32'(eTrap && !eDir));
    if (eTrap)
      check(trapCode == ow, {tag, "/R5"}, "trapCode", 32'(trapCode), 32'(ow));
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    step("R7", 1'b1, sel, d, 1'b1, 1'b0, 16'h0, 1'b0, 16'h0);
  endtask

  task automatic acc(input string tag, input logic [15:0] a);
    step(tag, 1'b0, 3'd0, 16'h0, 1'b0, 1'b1, a, 1'b0, 16'h0);
  endtask

  task automatic fetch(input string tag, input logic [15:0] w);
    step(tag, 1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b1, w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!memStrobe, "R8", "memStrobe", 32'(memStrobe), 0);
    check(!faultIrq && !directStrobe && !kernelStrobe, "R8", "strobes",
          {29'd0, faultIrq, directStrobe, kernelStrobe}, 0);
    check(faultAddr == 16'h0 && trapCode == 16'h0, "R8", "captures",
          {faultAddr, trapCode}, 0);
    @(negedge clk);

    // R8: full limit, zero base, empty windows
    acc("R8", 16'hFFFF);
    acc("R8", 16'h0000);
    fetch("R8", 16'hFFFF);
    fetch("R8", 16'h0000);
    fetch("R8", 16'h8000);

    // R7: writes ignored without supervisor, and for unused selects
    step("R7", 1'b1, 3'd0, 16'h0100, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0);
    step("R7", 1'b1, 3'd1, 16'h0010, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0);
    acc("R7", 16'h0020);
    wr(3'd6, 16'h1111);
    wr(3'd7, 16'h2222);
    acc("R7", 16'hFFFF);
    // R7: base write in the same cycle as an access uses the old base
    step("R7", 1'b1, 3'd0, 16'h0100, 1'b1, 1'b1, 16'h0040, 1'b0, 16'h0);
    acc("R7", 16'h0040);

    // R1 R2 R3: address sweeps over three base/limit pairs
    for (int c = 0; c < 3; c++) begin
      case (c)
        0: begin wr(3'd0, 16'h0100); wr(3'd1, 16'h00FF); end
        1: begin wr(3'd0, 16'hFFF0); wr(3'd1, 16'hFFFF); end
        default: begin wr(3'd0, 16'h1234); wr(3'd1, 16'h0010); end
      endcase
      for (int a = 0; a < 512; a++) acc("R2", 16'(a));
      for (int a = 65280; a < 65536; a++) acc("R3", 16'(a));
    end

    // R5 R6: trap window with a direct subset inside it
    wr(3'd2, 16'hF000); wr(3'd3, 16'hF0FF);
    wr(3'd4, 16'hF010); wr(3'd5, 16'hF01F);
    for (int w = 16'hEF00; w < 16'hF200; w++) fetch("R5", 16'(w));
    fetch("R6", 16'hF000);
    fetch("R6", 16'hF010);
    fetch("R6", 16'hF01F);
    fetch("R6", 16'hF020);

    // R6: direct window wider than the trap window
    wr(3'd2, 16'h7FF0); wr(3'd3, 16'h800F);
    wr(3'd4, 16'h0000); wr(3'd5, 16'hFFFF);
    for (int w = 16'h7F00; w < 16'h8100; w++) fetch("R6", 16'(w));

    // R9: faults and traps in the same cycle
    wr(3'd0, 16'hFF00); wr(3'd1, 16'h0080);
    wr(3'd4, 16'h7FF8); wr(3'd5, 16'h8003);
    for (int i = 0; i < 512; i++)
      step("R9", 1'b0, 3'd0, 16'h0, 1'b0, 1'b1, 16'(i * 3), 1'b1, 16'(16'h7FE0 + i / 8));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule